// File: doc/BRIEF.md
# Synchronous Two-Port 9-Bit Word Memory with Split Write Lanes

This block is a memory of 2^ADDR_W words, 4096 by default, each BYTE_W+1 bits (9 by default). Two ports, left and right, reach the same array at the same time, and each port runs on its own clock. Every port input except the output enables is captured at the rising edge of that port's clock. A stall input freezes the capture so that the edge does nothing new on that port.

Each word splits into a byte lane (bits BYTE_W-1..0) and a single top bit lane (bit BYTE_W). Each lane has its own read/write control and its own active-low output enable. One lane can therefore be written while the other lane is read in the same access.

A write is sampled at one edge and lands in the array at the next edge of the same port. Read data is sampled with the address and appears after that same edge. It then stays on the output until a later read of that lane replaces it. When a read is followed by a write on the same port, one deselected cycle must separate them. When both ports commit the same lane of the same word at one edge, the left port's value is kept.

Top module: `dp_sync_ram9`

## Requirements
- R1: After rst_ni is asserted, both ports are deselected: `rdata_*_o` is 0 and `lane_vld_*_o` is 00. Every array word reads as 0 until it is written.
- R2: A read samples `sel_n` low, the address and `rw` high for a lane at a rising edge. That lane of the addressed word is on `rdata_*_o` right after the same edge.
- R3: At an edge where `stall_*_i` is 1, nothing is captured. The port's output data and flags stay as they were, and no write is started.
- R4: An edge that samples `sel_n_*_i` high deselects the port. There is no read and no write, and both lane flags go to 0.
- R5: Lane index 0 of `rw_*_i`, `oe_n_*_i` and `lane_vld_*_o` controls data bits BYTE_W-1..0. Lane index 1 controls bit BYTE_W. A lane write (`rw` 0) changes only that lane's bits.
- R6: In one access, one lane can be written while the other lane is read. The read lane returns the word's value from before the write.
- R7: `lane_vld_*_o[l]` is 1 exactly when `oe_n_*_i[l]` is 0 and the last captured access reads lane l. This is combinational in `oe_n`.
- R8: A write sampled at edge k is stored at edge k+1. A same-port read sampled at edge k+1 returns the old value. A read sampled at edge k+2 returns the new value.
- R9: A word written through one port is returned by a read on the other port that is sampled after the commit edge.
- R10: If both ports commit the same lane of the same address at one edge, the left value is stored. Different lanes of the same word written at one edge both land.
- R11: A lane's output data holds its last read value through deselected, write and stalled cycles.
- R12: A read, then one deselected cycle, then a write on the same port stores the written word correctly. This includes the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| clk_r_i | input | 1 | Right port clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the port registers |
| stall_l_i | input | 1 | Left stall: 1 holds all left input registers |
| sel_n_l_i | input | 1 | Left select, active low |
| addr_l_i | input | ADDR_W | Left word address |
| wdata_l_i | input | BYTE_W+1 | Left write data |
| rw_l_i | input | 2 | Left per-lane control, 1 read, 0 write |
| oe_n_l_i | input | 2 | Left per-lane output enable, active low, combinational |
| rdata_l_o | output | BYTE_W+1 | Left read data |
| lane_vld_l_o | output | 2 | Left per-lane data-driven flags |
| stall_r_i | input | 1 | Right stall |
| sel_n_r_i | input | 1 | Right select, active low |
| addr_r_i | input | ADDR_W | Right word address |
| wdata_r_i | input | BYTE_W+1 | Right write data |
| rw_r_i | input | 2 | Right per-lane control, 1 read, 0 write |
| oe_n_r_i | input | 2 | Right per-lane output enable, active low |
| rdata_r_o | output | BYTE_W+1 | Right read data |
| lane_vld_r_o | output | 2 | Right per-lane data-driven flags |

## Verification
The bench builds the block with ADDR_W=5 and BYTE_W=8. It drives both ports from one clock, so that same-edge collisions between the ports are well defined. The small depth puts the top address, 31, within easy reach for the turnaround case. It also keeps the zero start state cheap to sweep. With a shared clock, the bench can also place a cross-port read exactly on the commit edge and one edge after it.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned N_RD      = 3;

  typedef enum int unsigned {PORT_L = 0, PORT_R = 1} port_e;
  typedef enum int unsigned {LANE_BYTE = 0, LANE_BIT = 1} lane_e;
endpackage

// File: rtl/dpr_port_stage.sv
module dpr_port_stage #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTE_W + 1,
  localparam int unsigned NL = dpr_pkg::NUM_LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              sel_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NL-1:0]     rw_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              sel_n_q_o,
  output logic [NL-1:0]     rw_q_o,
  output logic [NL-1:0]     commit_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sel_n_q;
  logic [NL-1:0]     rw_q;
  logic              fresh_q;
  logic [NL-1:0]     take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      sel_n_q <= 1'b1;
      rw_q    <= '1;
      fresh_q <= 1'b0;
    end else if (!stall_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      sel_n_q <= sel_n_i;
      rw_q    <= rw_i;
      fresh_q <= 1'b1;
    end else begin
      fresh_q <= 1'b0;
    end
  end

  // commit once, on the edge after capture, even if that edge stalls
  assign commit_o = {NL{fresh_q & ~sel_n_q}} & ~rw_q;
  assign take     = {NL{~stall_i & ~sel_n_i}} & rw_i;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int unsigned LO = (l == int'(dpr_pkg::LANE_BYTE)) ? 0 : BYTE_W;
    localparam int unsigned WD = (l == int'(dpr_pkg::LANE_BYTE)) ? BYTE_W : 1;
    logic [WD-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q <= '0;
      else if (take[l]) lane_q <= rd_word_i[LO +: WD];
    end
    assign rdata_o[LO +: WD] = lane_q;
  end

  assign addr_q_o  = addr_q;
  assign wdata_q_o = wdata_q;
  assign sel_n_q_o = sel_n_q;
  assign rw_q_o    = rw_q;
endmodule

// File: rtl/dpr_lane_gate.sv
module dpr_lane_gate #(
  localparam int unsigned NL = dpr_pkg::NUM_LANES
) (
  input  logic          sel_n_q_i,
  input  logic [NL-1:0] rw_q_i,
  input  logic [NL-1:0] oe_n_i,
  output logic [NL-1:0] vld_o
);
  always_comb begin
    for (int l = 0; l < NL; l++) begin
      vld_o[l] = ~oe_n_i[l] & ~sel_n_q_i & rw_q_i[l];
    end
  end
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DATA_W = BYTE_W + 1,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned NL = dpr_pkg::NUM_LANES,
  localparam int unsigned NR = dpr_pkg::N_RD
) (
  input  logic              clk_i,
  input  logic [NL-1:0]     we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i [NR],
  output logic [DATA_W-1:0] rdata_o [NR]
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mask;

  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem[i] = '0;
  end

  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      mask[i] = (i < int'(BYTE_W)) ? we_i[dpr_pkg::LANE_BYTE] : we_i[dpr_pkg::LANE_BIT];
    end
  end

  always_ff @(posedge clk_i) begin
    if (|we_i) mem[waddr_i] <= (mem[waddr_i] & ~mask) | (wdata_i & mask);
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/dp_sync_ram9.sv
module dp_sync_ram9 #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_l_i,
  input  logic                clk_r_i,
  input  logic                rst_ni,
  input  logic                stall_l_i,
  input  logic                sel_n_l_i,
  input  logic [ADDR_W-1:0]   addr_l_i,
  input  logic [BYTE_W:0]     wdata_l_i,
  input  logic [1:0]          rw_l_i,
  input  logic [1:0]          oe_n_l_i,
  output logic [BYTE_W:0]     rdata_l_o,
  output logic [1:0]          lane_vld_l_o,
  input  logic                stall_r_i,
  input  logic                sel_n_r_i,
  input  logic [ADDR_W-1:0]   addr_r_i,
  input  logic [BYTE_W:0]     wdata_r_i,
  input  logic [1:0]          rw_r_i,
  input  logic [1:0]          oe_n_r_i,
  output logic [BYTE_W:0]     rdata_r_o,
  output logic [1:0]          lane_vld_r_o
);
  localparam int unsigned DATA_W = BYTE_W + 1;
  localparam int unsigned NP = dpr_pkg::NUM_PORTS;
  localparam int unsigned NL = dpr_pkg::NUM_LANES;
  localparam int unsigned NR = dpr_pkg::N_RD;

  logic [NP-1:0]     clk_p, stall_p, sel_n_p, sel_n_q;
  logic [ADDR_W-1:0] addr_p [NP];
  logic [ADDR_W-1:0] addr_q [NP];
  logic [DATA_W-1:0] wdata_p [NP];
  logic [DATA_W-1:0] wdata_q [NP];
  logic [DATA_W-1:0] rdata_p [NP];
  logic [DATA_W-1:0] rd_word [NP];
  logic [DATA_W-1:0] bank_wd [NP];
  logic [NL-1:0]     rw_p [NP];
  logic [NL-1:0]     rw_q [NP];
  logic [NL-1:0]     oe_n_p [NP];
  logic [NL-1:0]     vld_p [NP];
  logic [NL-1:0]     commit [NP];
  logic [NL-1:0]     bank_we [NP];
  logic [ADDR_W-1:0] bank_ra [NP][NR];
  logic [DATA_W-1:0] bank_rd [NP][NR];
  logic              same_addr;

  assign clk_p      = {clk_r_i, clk_l_i};
  assign stall_p    = {stall_r_i, stall_l_i};
  assign sel_n_p    = {sel_n_r_i, sel_n_l_i};
  assign addr_p[0]  = addr_l_i;
  assign addr_p[1]  = addr_r_i;
  assign wdata_p[0] = wdata_l_i;
  assign wdata_p[1] = wdata_r_i;
  assign rw_p[0]    = rw_l_i;
  assign rw_p[1]    = rw_r_i;
  assign oe_n_p[0]  = oe_n_l_i;
  assign oe_n_p[1]  = oe_n_r_i;

  assign rdata_l_o    = rdata_p[0];
  assign rdata_r_o    = rdata_p[1];
  assign lane_vld_l_o = vld_p[0];
  assign lane_vld_r_o = vld_p[1];

  assign same_addr = (addr_q[0] == addr_q[1]);

  // one bank per writer; stored word = XOR of both banks at the address
  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_port_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_stage (
      .clk_i     (clk_p[p]),
      .rst_ni    (rst_ni),
      .stall_i   (stall_p[p]),
      .sel_n_i   (sel_n_p[p]),
      .addr_i    (addr_p[p]),
      .wdata_i   (wdata_p[p]),
      .rw_i      (rw_p[p]),
      .rd_word_i (rd_word[p]),
      .addr_q_o  (addr_q[p]),
      .wdata_q_o (wdata_q[p]),
      .sel_n_q_o (sel_n_q[p]),
      .rw_q_o    (rw_q[p]),
      .commit_o  (commit[p]),
      .rdata_o   (rdata_p[p])
    );

    dpr_lane_gate u_gate (
      .sel_n_q_i (sel_n_q[p]),
      .rw_q_i    (rw_q[p]),
      .oe_n_i    (oe_n_p[p]),
      .vld_o     (vld_p[p])
    );

    assign rd_word[p]    = bank_rd[0][p] ^ bank_rd[1][p];
    assign bank_ra[p][0] = addr_p[0];
    assign bank_ra[p][1] = addr_p[1];
    assign bank_ra[p][2] = addr_q[NP-1-p];
    assign bank_wd[p]    = wdata_q[p] ^ bank_rd[NP-1-p][2];

    if (p == int'(dpr_pkg::PORT_L)) begin : g_pri
      assign bank_we[p] = commit[p];
    end else begin : g_sec
      // left wins a same-lane, same-word collision
      assign bank_we[p] = commit[p] & ~(commit[0] & {NL{same_addr}});
    end

    dpr_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
      .clk_i   (clk_p[p]),
      .we_i    (bank_we[p]),
      .waddr_i (addr_q[p]),
      .wdata_i (bank_wd[p]),
      .raddr_i (bank_ra[p]),
      .rdata_o (bank_rd[p])
    );
  end
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BYTE_W = 8
) (
  input logic            clk_l_i,
  input logic            clk_r_i,
  input logic            rst_ni,
  input logic            stall_l_i,
  input logic            sel_n_l_i,
  input logic [1:0]      rw_l_i,
  input logic [1:0]      oe_n_l_i,
  input logic [BYTE_W:0] rdata_l_o,
  input logic [1:0]      lane_vld_l_o,
  input logic            stall_r_i,
  input logic            sel_n_r_i,
  input logic [1:0]      lane_vld_r_o
);
  p_desel_left_r4: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!stall_l_i && sel_n_l_i) |=> (lane_vld_l_o == 2'b00));

  p_desel_right_r4: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (!stall_r_i && sel_n_r_i) |=> (lane_vld_r_o == 2'b00));

  p_stall_holds_r3: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    stall_l_i |=> $stable(rdata_l_o));

  p_byte_write_silent_r6: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!stall_l_i && !sel_n_l_i && !rw_l_i[0]) |=> !lane_vld_l_o[0]);

  p_byte_held_r11: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!stall_l_i && (sel_n_l_i || !rw_l_i[0])) |=> $stable(rdata_l_o[BYTE_W-1:0]));

  p_oe_masks_bit_r7: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    oe_n_l_i[1] |-> !lane_vld_l_o[1]);
endmodule

bind dp_sync_ram9 dpr_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_l_i      (clk_l_i),
  .clk_r_i      (clk_r_i),
  .rst_ni       (rst_ni),
  .stall_l_i    (stall_l_i),
  .sel_n_l_i    (sel_n_l_i),
  .rw_l_i       (rw_l_i),
  .oe_n_l_i     (oe_n_l_i),
  .rdata_l_o    (rdata_l_o),
  .lane_vld_l_o (lane_vld_l_o),
  .stall_r_i    (stall_r_i),
  .sel_n_r_i    (sel_n_r_i),
  .lane_vld_r_o (lane_vld_r_o)
);

// File: tb/dp_sync_ram9_tb_top.sv
module dp_sync_ram9_tb_top;
  localparam int AW = 5;
  localparam int BW = 8;
  localparam int DW = BW + 1;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]    stall, seln;
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd [2];
  logic [1:0]    rw [2];
  logic [1:0]    oen [2];
  logic [DW-1:0] rd_o [2];
  logic [1:0]    vld_o [2];

  dp_sync_ram9 #(.ADDR_W(AW), .BYTE_W(BW)) dut_i (
    .clk_l_i(clk), .clk_r_i(clk), .rst_ni(rst_ni),
    .stall_l_i(stall[0]), .sel_n_l_i(seln[0]), .addr_l_i(addr[0]), .wdata_l_i(wd[0]),
    .rw_l_i(rw[0]), .oe_n_l_i(oen[0]), .rdata_l_o(rd_o[0]), .lane_vld_l_o(vld_o[0]),
    .stall_r_i(stall[1]), .sel_n_r_i(seln[1]), .addr_r_i(addr[1]), .wdata_r_i(wd[1]),
    .rw_r_i(rw[1]), .oe_n_r_i(oen[1]), .rdata_r_o(rd_o[1]), .lane_vld_r_o(vld_o[1])
  );

  int unsigned n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference
  logic [DW-1:0] mdl [WORDS];
  logic [DW-1:0] e_rd [2];
  logic [1:0]    e_sel [2];
  logic [1:0]    p_we [2];
  logic [AW-1:0] p_a [2];
  logic [DW-1:0] p_d [2];

  function automatic logic [DW-1:0] lmask(int l);
    return (l == 0) ? DW'((1 << BW) - 1) : DW'(1 << BW);
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) mdl[i] = '0;
    for (int p = 0; p < 2; p++) begin
      e_rd[p] = '0; e_sel[p] = '0; p_we[p] = '0; p_a[p] = '0; p_d[p] = '0;
      stall[p] = 1'b0; seln[p] = 1'b1; addr[p] = '0; wd[p] = '0; rw[p] = 2'b11; oen[p] = 2'b00;
    end
  end

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int p = 0; p < 2; p++) begin e_rd[p] = '0; e_sel[p] = '0; p_we[p] = '0; end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (!stall[p]) begin
          if (seln[p]) e_sel[p] = 2'b00;
          else begin
            e_sel[p] = rw[p];
            for (int l = 0; l < 2; l++)
              if (rw[p][l]) e_rd[p] = (e_rd[p] & ~lmask(l)) | (mdl[addr[p]] & lmask(l));
          end
        end
      end
      for (int p = 1; p >= 0; p--)
        for (int l = 0; l < 2; l++)
          if (p_we[p][l]) mdl[p_a[p]] = (mdl[p_a[p]] & ~lmask(l)) | (p_d[p] & lmask(l));
      for (int p = 0; p < 2; p++) begin
        if (!stall[p] && !seln[p]) begin
          p_we[p] = ~rw[p]; p_a[p] = addr[p]; p_d[p] = wd[p];
        end else p_we[p] = 2'b00;
      end
    end
  end

  task automatic check_all();
    for (int p = 0; p < 2; p++) begin
      logic [1:0] ev;
      ev = e_sel[p] & ~oen[p];
      n_chk++;
      if (rd_o[p] !== e_rd[p] || vld_o[p] !== ev) begin
        n_bad++;
        $display("FAIL %s port %0d: rdata=%h vld=%b expected rdata=%h vld=%b",
                 tag, p, rd_o[p], vld_o[p], e_rd[p], ev);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(int p);
    stall[p] = 1'b0; seln[p] = 1'b1; rw[p] = 2'b11;
  endtask

  task automatic acc(int p, logic [1:0] r, logic [AW-1:0] a, logic [DW-1:0] d);
    stall[p] = 1'b0; seln[p] = 1'b0; rw[p] = r; addr[p] = a; wd[p] = d;
  endtask

  initial begin
    // R1: reset state and zero contents
    tag = "R1";
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    acc(0, 2'b11, 5'd0, '0); acc(1, 2'b11, 5'd31, '0); step();
    idle(0); idle(1); step();

    // R2: write then read back
    tag = "R2";
    acc(0, 2'b00, 5'd3, 9'h1A5); step();
    idle(0); step();
    acc(0, 2'b11, 5'd3, '0); step();
    idle(0); step();

    // R8: same-port read on the commit edge sees old data
    tag = "R8";
    acc(0, 2'b00, 5'd4, 9'h0F0); step();
    acc(0, 2'b11, 5'd4, '0); step();
    acc(0, 2'b11, 5'd4, '0); step();
    idle(0); step();

    // R9: cross-port visibility
    tag = "R9";
    acc(0, 2'b00, 5'd7, 9'h155); step();
    idle(0); acc(1, 2'b11, 5'd7, '0); step();
    acc(1, 2'b11, 5'd7, '0); step();
    idle(1); step();

    // R5/R6: lane split, write one lane while reading the other
    tag = "R5";
    acc(0, 2'b10, 5'd3, 9'h033); step();
    idle(0); step();
    acc(0, 2'b11, 5'd3, '0); step();
    idle(0); step();
    tag = "R6";
    acc(0, 2'b01, 5'd3, 9'h000); step();
    idle(0); step();
    acc(0, 2'b11, 5'd3, '0); step();

    // R7: combinational output enables
    tag = "R7";
    oen[0] = 2'b11; step();
    oen[0] = 2'b01; step();
    oen[0] = 2'b10; step();
    oen[0] = 2'b00; idle(0); step();

    // R3: stall ignores a write and freezes a read
    tag = "R3";
    acc(0, 2'b00, 5'd3, 9'h1FF); stall[0] = 1'b1; step();
    step();
    idle(0); step();
    acc(0, 2'b11, 5'd4, '0); step();
    acc(0, 2'b11, 5'd3, '0); stall[0] = 1'b1; step();
    step();
    stall[0] = 1'b0; idle(0); step();
    acc(0, 2'b11, 5'd3, '0); step();
    idle(0); step();

    // R4: deselect blocks a write
    tag = "R4";
    acc(0, 2'b00, 5'd3, 9'h1FF); seln[0] = 1'b1; step();
    idle(0); step();
    acc(0, 2'b11, 5'd3, '0); step();
    idle(0); step();

    // R10: collisions
    tag = "R10";
    acc(0, 2'b00, 5'd9, 9'h0AA); acc(1, 2'b00, 5'd9, 9'h155); step();
    idle(0); idle(1); step();
    acc(0, 2'b11, 5'd9, '0); step();
    idle(0); step();
    acc(0, 2'b10, 5'd10, 9'h011); acc(1, 2'b01, 5'd10, 9'h100); step();
    idle(0); idle(1); step();
    acc(1, 2'b11, 5'd10, '0); step();
    idle(1); step();

    // R12: read, dead cycle, write at the top address
    tag = "R12";
    acc(0, 2'b11, 5'd31, '0); step();
    idle(0); step();
    acc(0, 2'b00, 5'd31, 9'h1C3); step();
    idle(0); step();
    acc(0, 2'b11, 5'd31, '0); step();
    idle(0); step();

    // R11: output held while the other port writes and this one idles
    tag = "R11";
    acc(1, 2'b00, 5'd31, 9'h00E); step();
    idle(1); step();
    repeat (3) step();
    acc(1, 2'b11, 5'd31, '0); step();
    idle(1); step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule